// File: doc/BRIEF.md
# Streaming Cross-Stencil Convolver

This block applies a 13-point cross-shaped stencil of radius three to a two-dimensional array of signed fixed-point samples. The array arrives row by row, left to right, at most one sample per clock. Each result is the weighted sum of a centre sample, its three nearest neighbours on the left and on the right within the same row, and its three nearest neighbours above and below within the same column. The thirteen weights come from a packed coefficient bus. Software holds that bus steady for the length of a frame.

Neighbours in the same column sit one full row apart in the stream. The block therefore keeps the six most recent rows in an on-chip row store of `ROW_W` words, each word six samples wide. A seven-sample horizontal shift register and short per-row delay lines line the vertical column up with the horizontal span. A three-stage multiply/add pipeline then produces the result. A result is only marked valid when the whole stencil lies inside the frame, so no padded border values are produced.

Top module: `star_stencil_conv`

## Requirements
- R1: After reset, `out_valid` is low, and the first accepted sample is treated as row 0, column 0 even if `frame_start` is not pulsed.
- R2: Each valid result for centre (r,c) is the sum of coefficient times sample over these 13 taps. Coefficient k occupies `coef[k*CW +: CW]`, and all values are signed two's complement. The tap order is: k=0 is the centre; k=1..3 are (r,c-1..c-3); k=4..6 are (r,c+1..c+3); k=7..9 are (r-1..r-3,c); k=10..12 are (r+1..r+3,c).
- R3: `out_valid` is produced exactly once for every centre with row ≥ 3, column from 3 to ROW_W-4, and at least three rows before the last row fed. Results appear in raster order, so an H-row frame yields (H-6)*(ROW_W-6) results.
- R4: A result appears on `out_valid`/`out_data` at the third rising edge after the edge that accepts sample (r+3,c+3).
- R5: A cycle with `in_valid` low accepts nothing and moves no position. Results of a stream with gaps equal those of the same stream fed without gaps.
- R6: `frame_start` together with `in_valid` makes that sample row 0, column 0. Rows seen before it never make a result valid.
- R7: `frame_start` while `in_valid` is low has no effect.
- R8: The full-precision sum is reduced to its low `OW` bits, wrapping on overflow.
- R9: The column position wraps to 0 after ROW_W accepted samples and the row position advances. The six preceding rows remain available across row ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_data` this cycle |
| frame_start | input | 1 | Marks the accepted sample as the frame origin |
| in_data | input | DW | Signed input sample |
| coef | input | 13*CW | Thirteen signed coefficients, tap k at bits k*CW |
| out_valid | output | 1 | Result on `out_data` is valid |
| out_data | output | OW | Signed stencil result, low OW bits |

## Verification
The bench builds the block with ROW_W=16, DW=12, CW=10 and OW=20. A 16-sample row lets several complete frames of seven to ten rows run in a short time while still exercising row wrap, the six-row store and both horizontal edges. The full sum is 26 bits but the output is only 20 bits, so near-full-scale samples with large coefficients force the wrap-around truncation to show up.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int REACH    = 3;
    localparam int SPAN     = 2 * REACH;
    localparam int NTAPS    = 4 * REACH + 1;
    localparam int PIPE_LAT = 3;
    localparam int GRP      = 4;
    localparam int NGRP     = (NTAPS + GRP - 1) / GRP;
endpackage

// File: rtl/sst_rowstore.sv
module sst_rowstore
    import sst_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ROW_W = 512,
    localparam int CIX  = $clog2(ROW_W)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [CIX-1:0]         col,
    input  logic [DW-1:0]          din,
    output logic [SPAN:0][DW-1:0]  column
);
    // one word per column, holding the six previous rows, newest in the low slot
    logic [SPAN*DW-1:0] mem [ROW_W];
    logic [SPAN*DW-1:0] rd;

    assign rd = mem[col];

    always_comb begin
        column[0] = din;
        for (int k = 1; k <= SPAN; k++) begin
            column[k] = rd[(k-1)*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[col] <= {rd[(SPAN-1)*DW-1:0], din};
        end
    end
endmodule

// File: rtl/sst_window.sv
module sst_window
    import sst_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ROW_W = 512,
    localparam int CIX  = $clog2(ROW_W),
    localparam int RW   = $clog2(SPAN + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    frame_start,
    input  logic [DW-1:0]           din,
    output logic [NTAPS-1:0][DW-1:0] taps,
    output logic                    win_valid
);
    typedef struct packed {
        logic [CIX-1:0]                    col;
        logic [RW-1:0]                     rows;
        logic [SPAN:0][DW-1:0]             hsr;
        logic [SPAN-1:0][REACH:0][DW-1:0]  vd;
        logic                              valid;
    } win_t;

    win_t q, d;
    logic [CIX-1:0]        cur_col;
    logic [RW-1:0]         cur_rows;
    logic                  last;
    logic [SPAN:0][DW-1:0] column;

    sst_rowstore #(.DW(DW), .ROW_W(ROW_W)) u_store (
        .clk    (clk),
        .we     (in_valid),
        .col    (cur_col),
        .din    (din),
        .column (column)
    );

    always_comb begin
        cur_col  = (in_valid && frame_start) ? '0 : q.col;
        cur_rows = (in_valid && frame_start) ? '0 : q.rows;
        last     = (cur_col == CIX'(ROW_W - 1));
        d        = q;
        d.valid  = 1'b0;
        if (in_valid) begin
            d.col  = last ? '0 : cur_col + 1'b1;
            d.rows = (last && cur_rows != RW'(SPAN)) ? cur_rows + 1'b1 : cur_rows;
            d.hsr[0] = column[REACH];
            for (int i = 1; i <= SPAN; i++) begin
                d.hsr[i] = q.hsr[i-1];
            end
            for (int j = 0; j < SPAN; j++) begin
                d.vd[j][0] = column[(j < REACH) ? j : j + 1];
                for (int s = 1; s <= REACH; s++) begin
                    d.vd[j][s] = q.vd[j][s-1];
                end
            end
            d.valid = (cur_rows == RW'(SPAN)) && (cur_col >= CIX'(SPAN));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        taps[0] = q.hsr[REACH];
        for (int k = 1; k <= REACH; k++) begin
            taps[k]           = q.hsr[REACH+k];
            taps[REACH+k]     = q.hsr[REACH-k];
            taps[2*REACH+k]   = q.vd[REACH-1+k][REACH];
            taps[3*REACH+k]   = q.vd[REACH-k][REACH];
        end
    end

    assign win_valid = q.valid;

    a_r9_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !frame_start && q.col == CIX'(ROW_W - 1) |=> q.col == '0);
    a_r6_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && frame_start |=> q.col == CIX'(1) && !q.valid);
    a_r5_idle_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !q.valid);
    a_r7_idle_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid && frame_start |=> $stable(q.col) && $stable(q.rows));
    a_r3_rows_cap: assert property (@(posedge clk) disable iff (!rst_n)
        q.rows <= RW'(SPAN));
endmodule

// File: rtl/sst_mac.sv
module sst_mac
    import sst_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int OW = 32,
    localparam int PW  = DW + CW,
    localparam int SPW = PW + $clog2(GRP),
    localparam int SW  = PW + $clog2(NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTAPS-1:0][DW-1:0] taps,
    input  logic                     win_valid,
    input  logic [NTAPS*CW-1:0]      coef,
    output logic [OW-1:0]            out_data,
    output logic                     out_valid
);
    typedef struct packed {
        logic [NTAPS-1:0][PW-1:0] prod;
        logic [NGRP-1:0][SPW-1:0] part;
        logic [OW-1:0]            res;
        logic [PIPE_LAT-1:0]      vpipe;
    } mac_t;

    mac_t q, d;
    logic signed [PW-1:0]  ta, tc;
    logic signed [SPW-1:0] acc;
    logic signed [SW-1:0]  total;

    always_comb begin
        d = q;
        for (int i = 0; i < NTAPS; i++) begin
            ta = PW'(signed'(taps[i]));
            tc = PW'(signed'(coef[i*CW +: CW]));
            d.prod[i] = ta * tc;
        end
        for (int g = 0; g < NGRP; g++) begin
            acc = '0;
            for (int m = 0; m < GRP; m++) begin
                if (g * GRP + m < NTAPS) begin
                    acc = acc + SPW'(signed'(q.prod[g*GRP+m]));
                end
            end
            d.part[g] = acc;
        end
        total = '0;
        for (int g = 0; g < NGRP; g++) begin
            total = total + SW'(signed'(q.part[g]));
        end
        d.res   = OW'(total);
        d.vpipe = {q.vpipe[PIPE_LAT-2:0], win_valid};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_data  = q.res;
    assign out_valid = q.vpipe[PIPE_LAT-1];

    a_r4_no_orphan_result: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid ##1 !q.vpipe[0] |=> !q.vpipe[1]);
endmodule

// File: rtl/star_stencil_conv.sv
module star_stencil_conv
    import sst_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int OW    = 32,
    parameter int ROW_W = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  frame_start,
    input  logic [DW-1:0]         in_data,
    input  logic [NTAPS*CW-1:0]   coef,
    output logic                  out_valid,
    output logic [OW-1:0]         out_data
);
    logic [NTAPS-1:0][DW-1:0] taps;
    logic                     win_valid;

    sst_window #(.DW(DW), .ROW_W(ROW_W)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .din         (in_data),
        .taps        (taps),
        .win_valid   (win_valid)
    );

    sst_mac #(.DW(DW), .CW(CW), .OW(OW)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .taps      (taps),
        .win_valid (win_valid),
        .coef      (coef),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/sim_star_stencil_conv.sv
`timescale 1ns/1ps
module sim_star_stencil_conv;
    localparam int DW = 12, CW = 10, OW = 20, ROW_W = 16, NT = 13, MAXH = 10;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, frame_start = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [NT*CW-1:0] coef = '0;
    logic out_valid;
    logic [OW-1:0] out_data;

    always #4 clk = ~clk;

    star_stencil_conv #(.DW(DW), .CW(CW), .OW(OW), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
        .in_data(in_data), .coef(coef), .out_valid(out_valid), .out_data(out_data));

    int checks = 0, fails = 0, cyc = 0, seen = 0, first_cyc = -1, drv_cyc = 0;
    int fr [MAXH][ROW_W];
    int cf [NT];
    logic [OW-1:0] exp_q [$];
    string tag = "R2";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            seen++;
            if (first_cyc < 0) first_cyc = cyc;
            if (exp_q.size() == 0) check(0, "R3", "unexpected result", longint'(out_data), 0);
            else begin
                logic [OW-1:0] e;
                e = exp_q.pop_front();
                check(out_data == e, tag, "result value", longint'(out_data), longint'(e));
            end
        end
    end

    task automatic set_coefs(int base, int step);
        for (int k = 0; k < NT; k++) begin
            cf[k] = base + k * step;
            coef[k*CW +: CW] = CW'(cf[k]);
        end
    endtask

    task automatic build(int h, int seed, bit big);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < ROW_W; c++)
                fr[r][c] = big ? 2047 - ((r + c + seed) % 5)
                               : ((r * 37 + c * 11 + seed * 53) % 4000) - 2000;
    endtask

    // R2: model of the tap order and weights
    task automatic expect_frame(int h, output int n);
        n = 0;
        for (int r = 3; r <= h - 4; r++)
            for (int c = 3; c <= ROW_W - 4; c++) begin
                longint s;
                s = longint'(cf[0]) * fr[r][c];
                for (int dd = 1; dd <= 3; dd++) begin
                    s += longint'(cf[dd])     * fr[r][c-dd];
                    s += longint'(cf[3+dd])   * fr[r][c+dd];
                    s += longint'(cf[6+dd])   * fr[r-dd][c];
                    s += longint'(cf[9+dd])   * fr[r+dd][c];
                end
                exp_q.push_back(OW'(s));
                n++;
            end
    endtask

    task automatic idle(bit fs);
        @(posedge clk); #1;
        in_valid = 1'b0; frame_start = fs;
    endtask

    task automatic drive_frame(int h, bit use_start, int gap_every, bit gap_start);
        int idx = 0;
        for (int r = 0; r < h; r++)
            for (int c = 0; c < ROW_W; c++) begin
                if (gap_every > 0 && (idx % gap_every) == gap_every - 1) idle(gap_start);
                @(posedge clk); #1;
                in_valid = 1'b1;
                frame_start = use_start && r == 0 && c == 0;
                in_data = DW'(fr[r][c]);
                if (r == 6 && c == 6) drv_cyc = cyc;
                idx++;
            end
        idle(1'b0);
    endtask

    task automatic settle(int n);
        repeat (12) idle(1'b0);
        check(seen == n, "R3", "result count", seen, n);
        check(exp_q.size() == 0, "R3", "missing results", exp_q.size(), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        repeat (4) idle(1'b0);
        @(negedge clk);
        check(out_valid == 1'b0, "R5", "out_valid while idle", out_valid, 0);
    endtask

    // R1, R2, R4, R9: first frame, no origin pulse, continuous
    task automatic t_first_frame();
        int n;
        set_coefs(-6, 1);
        build(10, 1, 1'b0);
        expect_frame(10, n);
        seen = 0; first_cyc = -1; tag = "R2";
        drive_frame(10, 1'b0, 0, 1'b0);
        settle(n);
        check(first_cyc == drv_cyc + 4, "R4", "first result cycle", first_cyc, drv_cyc + 4);
        check(n == 4 * 10, "R9", "expected count over wrapped rows", n, 40);
    endtask

    // R5, R7: gaps, with origin pulses during idle cycles
    task automatic t_gaps();
        int n;
        set_coefs(9, -2);
        build(9, 7, 1'b0);
        expect_frame(9, n);
        seen = 0; tag = "R5";
        drive_frame(9, 1'b1, 5, 1'b1);
        settle(n);
    endtask

    // R6: aborted frame mid-row, then restart
    task automatic t_restart();
        int n;
        set_coefs(3, 1);
        build(MAXH, 11, 1'b0);
        seen = 0; tag = "R6";
        for (int i = 0; i < 5 * ROW_W + 7; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; frame_start = (i == 0); in_data = DW'(i * 13);
        end
        idle(1'b0);
        build(8, 4, 1'b0);
        expect_frame(8, n);
        drive_frame(8, 1'b1, 0, 1'b0);
        settle(n);
        check(n == 2 * 10, "R6", "results from restarted frame only", seen, 20);
    endtask

    // R8: wrap of the full sum into OW bits
    task automatic t_wrap();
        int n;
        set_coefs(255, 0);
        build(7, 2, 1'b1);
        expect_frame(7, n);
        seen = 0; tag = "R8";
        drive_frame(7, 1'b1, 0, 1'b0);
        settle(n);
    endtask

    initial begin
        t_reset();
        t_first_frame();
        t_gaps();
        t_restart();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule